// File: doc/BRIEF.md
# Accumulator and Register-File Execute Unit

This unit executes the data-processing part of a 14-bit instruction set for a small machine built around one working register (the accumulator, W) and a file of byte registers. Each cycle in which `instr_valid` is high, the unit decodes `instr`. It reads the addressed file register combinationally and runs the arithmetic or logic operation. In the same clock edge it updates W and the carry, digit-carry and zero flags, and writes the file register through its write port.

A `skip_req` output tells the surrounding sequencer to discard the next instruction. It is raised by the bit-test instructions and by the count-and-test instructions. Branches, calls, returns, program-counter logic, pin read-back and timer side effects belong to other blocks. Their encodings pass through this unit with no effect.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, W, C, DC and Z are cleared to 0 at that edge. After reset, with `instr_valid` low, `rf_we` and `skip_req` are 0.
- R2: Byte instructions have bits [13:12]=00, an opcode in [11:8], a destination bit in [7] and an address in [6:0]. Destination 0 puts the result in W and leaves the file unwritten. Destination 1 writes the result to the addressed register and leaves W unchanged.
- R3: Add (byte opcode 0111, or literal [11:8]=111x) forms W plus the operand. C is the carry out of bit 7 and DC is the carry out of bit 3. Z is set when the 8-bit result is zero.
- R4: Subtract (byte opcode 0010 computes f−W; literal [11:8]=110x computes k−W) is two's complement. C=1 means no borrow from bit 7 and DC=1 means no borrow from bit 3, so 1−2 gives 0xFF with C=0.
- R5: The following update Z only and keep C and DC: AND 0101, IOR 0100, XOR 0110, complement 1001, decrement 0011, increment 1010 and move-file 1000.
- R6: Byte opcode 0001 clears W (destination 0) or the addressed register (destination 1), and always sets Z.
- R7: RLF (1101) shifts left with the old C entering bit 0 and bit 7 leaving to C. RRF (1100) shifts right with the old C entering bit 7 and bit 0 leaving to C. Both change only C.
- R8: SWAP (1110) exchanges the nibbles of the operand. Opcode 0000 with bit 7 set stores W to the register. Neither changes a flag.
- R9: Bit instructions have [13:12]=01, a sub-opcode in [11:10], a bit index in [9:7] and an address in [6:0]. Sub-opcode 00 clears the selected bit of the register and 01 sets it. Neither changes a flag or W.
- R10: Bit sub-opcode 10 raises `skip_req` when the selected bit is 0, and 11 raises it when the bit is 1. Neither writes anything or changes a flag.
- R11: Decrement-and-test (1011) and increment-and-test (1111) write their result to the destination and change no flag. They raise `skip_req` when the result is zero.
- R12: Literal instructions have [13:12]=11 and the 8-bit constant in [7:0]. Opcode 1001 is AND, 1000 is IOR and 1010 is XOR, all updating Z only. Opcode 00xx loads the constant into W with no flag change. All results go to W.
- R13: The following change no state and raise no request: prefix 10, literal [11:8] of 01xx or 1011, and byte opcode 0000 with bit 7 clear.
- R14: With `instr_valid` low, W and the flags hold, `rf_we` is 0 and `skip_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of W and flags |
| instr_valid | input | 1 | Instruction on `instr` executes at the next edge |
| instr | input | 14 | Instruction word |
| w_out | output | 8 | Current accumulator value |
| rf_we | output | 1 | File write strobe for the executing instruction |
| rf_addr | output | ADDR_W | File write address |
| rf_wdata | output | 8 | File write data |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_dc | output | 1 | Digit carry / no-borrow flag from bit 3 |
| flag_z | output | 1 | Zero flag |
| skip_req | output | 1 | Request to discard the following instruction |

## Verification
The bench builds the unit with the default ADDR_W of 7, which gives a file of 128 entries. Every entry is first loaded through the normal move instructions. Random instructions then hit the whole address space, so a wrong write address or a missed write shows up when a later move reads that entry back. Directed cases cover the carry boundaries: zero results of add and subtract, a borrow from a low nibble, a rotate through a set carry, and count-and-test reaching zero from 0xFF and from 0x01.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    localparam int INSTR_W = 14;
    localparam int DATA_W  = 8;
    localparam int FADDR_W = 7;
    localparam int BIT_W   = 3;

    typedef enum logic [4:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_IOR,
        OP_XOR,
        OP_COM,
        OP_DEC,
        OP_INC,
        OP_MOV,
        OP_RLF,
        OP_RRF,
        OP_SWAP,
        OP_CLR,
        OP_PASSW,
        OP_BCLR,
        OP_BSET
    } alu_op_e;

    typedef struct packed {
        alu_op_e                op;
        logic                   use_lit;
        logic                   wr_w;
        logic                   wr_f;
        logic                   upd_c;
        logic                   upd_dc;
        logic                   upd_z;
        logic                   skip_on_zero;
        logic                   skip_on_bit;
        logic                   skip_level;
        logic [BIT_W-1:0]       bit_idx;
        logic [FADDR_W-1:0]     addr;
        logic [DATA_W-1:0]      lit;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              c;
        logic              dc;
        logic              z;
    } alu_out_t;

    function automatic logic [DATA_W-1:0] bit_mask(input logic [BIT_W-1:0] idx);
        return DATA_W'(1) << idx;
    endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_exec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    logic       dbit;
    logic [3:0] opc;

    assign dbit = instr[7];
    assign opc  = instr[11:8];

    always_comb begin
        dec              = '0;
        dec.op           = OP_NONE;
        dec.addr         = instr[FADDR_W-1:0];
        dec.lit          = instr[DATA_W-1:0];
        dec.bit_idx      = instr[9:7];
        unique case (instr[13:12])
            2'b00: begin
                dec.wr_w = !dbit;
                dec.wr_f = dbit;
                unique case (opc)
                    4'b0000: begin
                        dec.wr_w = 1'b0;
                        if (dbit) dec.op = OP_PASSW;
                        else      dec.wr_f = 1'b0;
                    end
                    4'b0001: begin dec.op = OP_CLR;  dec.upd_z = 1'b1; end
                    4'b0010: begin dec.op = OP_SUB;  dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1; end
                    4'b0111: begin dec.op = OP_ADD;  dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1; end
                    4'b0011: begin dec.op = OP_DEC;  dec.upd_z = 1'b1; end
                    4'b1010: begin dec.op = OP_INC;  dec.upd_z = 1'b1; end
                    4'b0100: begin dec.op = OP_IOR;  dec.upd_z = 1'b1; end
                    4'b0101: begin dec.op = OP_AND;  dec.upd_z = 1'b1; end
                    4'b0110: begin dec.op = OP_XOR;  dec.upd_z = 1'b1; end
                    4'b1000: begin dec.op = OP_MOV;  dec.upd_z = 1'b1; end
                    4'b1001: begin dec.op = OP_COM;  dec.upd_z = 1'b1; end
                    4'b1011: begin dec.op = OP_DEC;  dec.skip_on_zero = 1'b1; end
                    4'b1111: begin dec.op = OP_INC;  dec.skip_on_zero = 1'b1; end
                    4'b1100: begin dec.op = OP_RRF;  dec.upd_c = 1'b1; end
                    4'b1101: begin dec.op = OP_RLF;  dec.upd_c = 1'b1; end
                    4'b1110: begin dec.op = OP_SWAP; end
                    default: begin dec.wr_w = 1'b0; dec.wr_f = 1'b0; end
                endcase
            end
            2'b01: begin
                unique case (instr[11:10])
                    2'b00: begin dec.op = OP_BCLR; dec.wr_f = 1'b1; end
                    2'b01: begin dec.op = OP_BSET; dec.wr_f = 1'b1; end
                    2'b10: begin dec.skip_on_bit = 1'b1; dec.skip_level = 1'b0; end
                    default: begin dec.skip_on_bit = 1'b1; dec.skip_level = 1'b1; end
                endcase
            end
            2'b11: begin
                dec.use_lit = 1'b1;
                if (opc[3:1] == 3'b111) begin
                    dec.op = OP_ADD; dec.wr_w = 1'b1;
                    dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1;
                end else if (opc[3:1] == 3'b110) begin
                    dec.op = OP_SUB; dec.wr_w = 1'b1;
                    dec.upd_c = 1'b1; dec.upd_dc = 1'b1; dec.upd_z = 1'b1;
                end else if (opc[3:2] == 2'b00) begin
                    dec.op = OP_MOV; dec.wr_w = 1'b1;
                end else begin
                    unique case (opc)
                        4'b1001: begin dec.op = OP_AND; dec.wr_w = 1'b1; dec.upd_z = 1'b1; end
                        4'b1000: begin dec.op = OP_IOR; dec.wr_w = 1'b1; dec.upd_z = 1'b1; end
                        4'b1010: begin dec.op = OP_XOR; dec.wr_w = 1'b1; dec.upd_z = 1'b1; end
                        default: dec.op = OP_NONE;
                    endcase
                end
            end
            default: dec.op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_exec_pkg::*;
(
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   opnd,
    input  logic [DATA_W-1:0]   wreg,
    input  logic                c_in,
    input  logic [BIT_W-1:0]    bit_idx,
    output alu_out_t            out
);

    localparam int HALF = DATA_W / 2;

    logic [DATA_W:0] sum_full;
    logic [HALF:0]   sum_low;
    logic [DATA_W:0] dif_full;
    logic [HALF:0]   dif_low;
    logic [DATA_W-1:0] mask;

    assign sum_full = {1'b0, opnd} + {1'b0, wreg};
    assign sum_low  = {1'b0, opnd[HALF-1:0]} + {1'b0, wreg[HALF-1:0]};
    assign dif_full = {1'b0, opnd} - {1'b0, wreg};
    assign dif_low  = {1'b0, opnd[HALF-1:0]} - {1'b0, wreg[HALF-1:0]};
    assign mask     = bit_mask(bit_idx);

    always_comb begin
        out.res = opnd;
        out.c   = c_in;
        out.dc  = 1'b0;
        unique case (op)
            OP_ADD:   begin out.res = sum_full[DATA_W-1:0]; out.c = sum_full[DATA_W]; out.dc = sum_low[HALF]; end
            OP_SUB:   begin out.res = dif_full[DATA_W-1:0]; out.c = !dif_full[DATA_W]; out.dc = !dif_low[HALF]; end
            OP_AND:   out.res = opnd & wreg;
            OP_IOR:   out.res = opnd | wreg;
            OP_XOR:   out.res = opnd ^ wreg;
            OP_COM:   out.res = ~opnd;
            OP_DEC:   out.res = opnd - DATA_W'(1);
            OP_INC:   out.res = opnd + DATA_W'(1);
            OP_RLF:   begin out.res = {opnd[DATA_W-2:0], c_in}; out.c = opnd[DATA_W-1]; end
            OP_RRF:   begin out.res = {c_in, opnd[DATA_W-1:1]}; out.c = opnd[0]; end
            OP_SWAP:  out.res = {opnd[HALF-1:0], opnd[DATA_W-1:HALF]};
            OP_CLR:   out.res = '0;
            OP_PASSW: out.res = wreg;
            OP_BCLR:  out.res = opnd & ~mask;
            OP_BSET:  out.res = opnd | mask;
            default:  out.res = opnd;
        endcase
        out.z = (out.res == '0);
    end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_exec_pkg::*;
#(
    parameter int ADDR_W = FADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                instr_valid,
    input  logic [INSTR_W-1:0]  instr,
    output logic [DATA_W-1:0]   w_out,
    output logic                rf_we,
    output logic [ADDR_W-1:0]   rf_addr,
    output logic [DATA_W-1:0]   rf_wdata,
    output logic                flag_c,
    output logic                flag_dc,
    output logic                flag_z,
    output logic                skip_req
);

    dec_t              dec;
    alu_out_t          ao;
    logic [DATA_W-1:0] rf_rd;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] w_q;
    logic              c_q, dc_q, z_q;
    logic              sel_bit;
    logic              byte_cls, bit_cls, out_cls;

    acc_decode u_dec (.instr(instr), .dec(dec));

    acc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .waddr (rf_addr),
        .wdata (rf_wdata),
        .raddr (dec.addr[ADDR_W-1:0]),
        .rdata (rf_rd)
    );

    assign operand = dec.use_lit ? dec.lit : rf_rd;

    acc_alu u_alu (
        .op      (dec.op),
        .opnd    (operand),
        .wreg    (w_q),
        .c_in    (c_q),
        .bit_idx (dec.bit_idx),
        .out     (ao)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q  <= '0;
            c_q  <= 1'b0;
            dc_q <= 1'b0;
            z_q  <= 1'b0;
        end else if (instr_valid) begin
            if (dec.wr_w)   w_q  <= ao.res;
            if (dec.upd_c)  c_q  <= ao.c;
            if (dec.upd_dc) dc_q <= ao.dc;
            if (dec.upd_z)  z_q  <= ao.z;
        end
    end

    assign sel_bit  = operand[dec.bit_idx];
    assign rf_we    = instr_valid && dec.wr_f;
    assign rf_addr  = dec.addr[ADDR_W-1:0];
    assign rf_wdata = ao.res;
    assign skip_req = instr_valid &&
                      ((dec.skip_on_zero && ao.z) ||
                       (dec.skip_on_bit && (sel_bit == dec.skip_level)));

    assign w_out   = w_q;
    assign flag_c  = c_q;
    assign flag_dc = dc_q;
    assign flag_z  = z_q;

    assign byte_cls = instr_valid && (instr[13:12] == 2'b00);
    assign bit_cls  = instr_valid && (instr[13:12] == 2'b01);
    assign out_cls  = instr_valid && (instr[13:12] == 2'b10);

    // R2: destination 0 never writes the file; destination 1 leaves W alone
    p_dest_w_r2: assert property (@(posedge clk) disable iff (rst)
        byte_cls && !instr[7] |-> !rf_we);
    p_dest_f_r2: assert property (@(posedge clk) disable iff (rst)
        byte_cls && instr[7] |=> $stable(w_out));

    // R3: add carry is the ninth bit of the true sum
    p_add_carry_r3: assert property (@(posedge clk) disable iff (rst)
        instr_valid && dec.op == OP_ADD |=>
        flag_c == (({1'b0, $past(operand)} + {1'b0, $past(w_out)}) > 9'd255));

    // R4: subtract carry means no borrow
    p_sub_carry_r4: assert property (@(posedge clk) disable iff (rst)
        instr_valid && dec.op == OP_SUB |=> flag_c == ($past(operand) >= $past(w_out)));

    // R5: zero-only instructions keep C and DC
    p_zonly_r5: assert property (@(posedge clk) disable iff (rst)
        instr_valid && dec.upd_z && !dec.upd_c |=> $stable(flag_c) && $stable(flag_dc));

    // R6: clears always set Z
    p_clr_z_r6: assert property (@(posedge clk) disable iff (rst)
        instr_valid && dec.op == OP_CLR |=> flag_z);

    // R7: rotates touch only carry
    p_rot_r7: assert property (@(posedge clk) disable iff (rst)
        instr_valid && (dec.op == OP_RLF || dec.op == OP_RRF) |=> $stable(flag_dc) && $stable(flag_z));

    // R8: swap and store-W leave every flag
    p_noflag_r8: assert property (@(posedge clk) disable iff (rst)
        instr_valid && (dec.op == OP_SWAP || dec.op == OP_PASSW) |=>
        $stable(flag_c) && $stable(flag_dc) && $stable(flag_z));

    // R9: bit clear/set write the file and leave W
    p_bitwr_r9: assert property (@(posedge clk) disable iff (rst)
        bit_cls && !instr[11] |-> rf_we);

    // R10: bit tests never write
    p_bittest_r10: assert property (@(posedge clk) disable iff (rst)
        bit_cls && instr[11] |-> !rf_we);

    // R11: count-and-test skips only on a zero result
    p_cnt_skip_r11: assert property (@(posedge clk) disable iff (rst)
        skip_req && byte_cls |-> rf_wdata == '0);

    // R13: out-of-scope encodings do nothing
    p_undef_r13: assert property (@(posedge clk) disable iff (rst)
        out_cls |-> !rf_we && !skip_req);
    p_undef_hold_r13: assert property (@(posedge clk) disable iff (rst)
        out_cls |=> $stable(w_out) && $stable(flag_c) && $stable(flag_dc) && $stable(flag_z));

    // R14: idle cycles hold state
    p_idle_r14: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !rf_we && !skip_req);
    p_idle_hold_r14: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(w_out) && $stable(flag_c) && $stable(flag_z));

endmodule

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [13:0] instr = '0;
    logic [7:0]  w_out;
    logic        rf_we;
    logic [6:0]  rf_addr;
    logic [7:0]  rf_wdata;
    logic        flag_c, flag_dc, flag_z, skip_req;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mw;
    logic       mc, mdc, mz;
    logic [7:0] mrf [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_exec_unit u_dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .w_out(w_out), .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .flag_c(flag_c), .flag_dc(flag_dc), .flag_z(flag_z), .skip_req(skip_req)
    );

    function automatic string tag_of(input logic [13:0] ins, input logic vld);
        if (!vld) return "R14";
        case (ins[13:12])
            2'b00: case (ins[11:8])
                4'b0000: return ins[7] ? "R8" : "R13";
                4'b0001: return "R6";
                4'b0010: return "R4";
                4'b0111: return "R3";
                4'b1100, 4'b1101: return "R7";
                4'b1110: return "R8";
                4'b1011, 4'b1111: return "R11";
                default: return "R5";
            endcase
            2'b01: return ins[11] ? "R10" : "R9";
            2'b11: begin
                if (ins[11:9] == 3'b111) return "R3";
                if (ins[11:9] == 3'b110) return "R4";
                if (ins[11:10] == 2'b00 || ins[11:8] == 4'b1001 ||
                    ins[11:8] == 4'b1000 || ins[11:8] == 4'b1010) return "R12";
                return "R13";
            end
            default: return "R13";
        endcase
    endfunction

    task automatic exec_chk(input logic [13:0] ins, input logic vld);
        logic [7:0] f, k, res, nw, ewd;
        logic       nc, ndc, nz, ewe, esk, upd, dst;
        logic [8:0] t9;
        string      tg;
        logic [7:0] a_wd; logic a_we, a_sk; logic [6:0] a_ad;
        tg  = tag_of(ins, vld);
        f   = mrf[ins[6:0]];
        k   = ins[7:0];
        nw  = mw; nc = mc; ndc = mdc; nz = mz;
        ewe = 1'b0; ewd = '0; esk = 1'b0; res = '0; upd = 1'b0;
        dst = ins[7];
        if (vld) begin
            case (ins[13:12])
                2'b00: begin
                    upd = 1'b1;
                    case (ins[11:8])
                        4'b0000: begin upd = 1'b0; if (dst) begin ewe = 1'b1; ewd = mw; end end
                        4'b0001: begin res = 8'h00; nz = 1'b1; end
                        4'b0010: begin res = f - mw; nc = (f >= mw); ndc = (f[3:0] >= mw[3:0]); nz = (res == 0); end
                        4'b0111: begin t9 = {1'b0, f} + {1'b0, mw}; res = t9[7:0]; nc = t9[8];
                                       ndc = ({1'b0, f[3:0]} + {1'b0, mw[3:0]}) > 5'd15; nz = (res == 0); end
                        4'b0011: begin res = f - 8'd1; nz = (res == 0); end
                        4'b1010: begin res = f + 8'd1; nz = (res == 0); end
                        4'b0100: begin res = f | mw; nz = (res == 0); end
                        4'b0101: begin res = f & mw; nz = (res == 0); end
                        4'b0110: begin res = f ^ mw; nz = (res == 0); end
                        4'b1000: begin res = f; nz = (res == 0); end
                        4'b1001: begin res = ~f; nz = (res == 0); end
                        4'b1011: begin res = f - 8'd1; esk = (res == 0); end
                        4'b1111: begin res = f + 8'd1; esk = (res == 0); end
                        4'b1100: begin res = {mc, f[7:1]}; nc = f[0]; end
                        4'b1101: begin res = {f[6:0], mc}; nc = f[7]; end
                        default: begin res = {f[3:0], f[7:4]}; end
                    endcase
                    if (upd) begin
                        if (dst) begin ewe = 1'b1; ewd = res; end
                        else nw = res;
                    end
                end
                2'b01: case (ins[11:10])
                    2'b00: begin ewe = 1'b1; ewd = f & ~(8'd1 << ins[9:7]); end
                    2'b01: begin ewe = 1'b1; ewd = f | (8'd1 << ins[9:7]); end
                    2'b10: esk = (f[ins[9:7]] == 1'b0);
                    default: esk = (f[ins[9:7]] == 1'b1);
                endcase
                2'b11: begin
                    if (ins[11:9] == 3'b111) begin
                        t9 = {1'b0, k} + {1'b0, mw}; nw = t9[7:0]; nc = t9[8];
                        ndc = ({1'b0, k[3:0]} + {1'b0, mw[3:0]}) > 5'd15; nz = (nw == 0);
                    end else if (ins[11:9] == 3'b110) begin
                        nw = k - mw; nc = (k >= mw); ndc = (k[3:0] >= mw[3:0]); nz = (nw == 0);
                    end else if (ins[11:10] == 2'b00) nw = k;
                    else if (ins[11:8] == 4'b1001) begin nw = k & mw; nz = (nw == 0); end
                    else if (ins[11:8] == 4'b1000) begin nw = k | mw; nz = (nw == 0); end
                    else if (ins[11:8] == 4'b1010) begin nw = k ^ mw; nz = (nw == 0); end
                end
                default: ;
            endcase
        end
        @(negedge clk);
        instr = ins; instr_valid = vld;
        #1;
        a_we = rf_we; a_ad = rf_addr; a_wd = rf_wdata; a_sk = skip_req;
        @(posedge clk);
        #1;
        checks++;
        if (a_we !== ewe || a_sk !== esk || (ewe && (a_ad !== ins[6:0] || a_wd !== ewd)) ||
            w_out !== nw || flag_c !== nc || flag_dc !== ndc || flag_z !== nz) begin
            fails++;
            $display("FAIL %s instr=%h act we=%b ad=%h wd=%h sk=%b w=%h c=%b dc=%b z=%b exp we=%b wd=%h sk=%b w=%h c=%b dc=%b z=%b",
                     tg, ins, a_we, a_ad, a_wd, a_sk, w_out, flag_c, flag_dc, flag_z,
                     ewe, ewd, esk, nw, nc, ndc, nz);
        end
        mw = nw; mc = nc; mdc = ndc; mz = nz;
        if (ewe) mrf[ins[6:0]] = ewd;
    endtask

    task automatic chk_val(input string tg, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tg, act, exp);
        end
    endtask

    function automatic logic [13:0] movlw(input logic [7:0] k); return {6'b110000, k}; endfunction
    function automatic logic [13:0] byteop(input logic [3:0] o, input logic d, input logic [6:0] a);
        return {2'b00, o, d, a};
    endfunction

    function automatic logic [13:0] rand_instr();
        logic [13:0] r;
        int sel;
        sel = $urandom_range(0, 9);
        r = 14'($urandom);
        if (sel < 5)      r[13:12] = 2'b00;
        else if (sel < 7) r[13:12] = 2'b01;
        else if (sel < 9) r[13:12] = 2'b11;
        else              r[13:12] = 2'b10;
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        mw = '0; mc = 1'b0; mdc = 1'b0; mz = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        checks++;
        if (w_out !== 8'h00 || flag_c !== 1'b0 || flag_dc !== 1'b0 || flag_z !== 1'b0 ||
            rf_we !== 1'b0 || skip_req !== 1'b0) begin
            fails++;
            $display("FAIL R1 act w=%h c=%b dc=%b z=%b we=%b sk=%b exp all zero",
                     w_out, flag_c, flag_dc, flag_z, rf_we, skip_req);
        end

        // preload every file entry (R12 move literal, R8 store W)
        for (int i = 0; i < 128; i++) begin
            exec_chk(movlw(8'(i * 37 + 5)), 1'b1);
            exec_chk(byteop(4'b0000, 1'b1, 7'(i)), 1'b1);
        end

        // R3 add: 0x17 + 0xC2 = 0xD9
        exec_chk(movlw(8'hC2), 1'b1);
        exec_chk(byteop(4'b0000, 1'b1, 7'd10), 1'b1);
        exec_chk(movlw(8'h17), 1'b1);
        exec_chk(byteop(4'b0111, 1'b0, 7'd10), 1'b1);
        chk_val("R3", w_out, 8'hD9);
        // R3 add to zero: 0x80 + 0x80 -> 0, C=1
        exec_chk(movlw(8'h80), 1'b1);
        exec_chk({6'b111110, 8'h80}, 1'b1);
        chk_val("R3", {5'd0, flag_c, flag_dc, flag_z}, 8'h05);
        // R4 subtract literal: k=2 minus W=1,2,3
        exec_chk(movlw(8'h01), 1'b1);
        exec_chk({6'b111100, 8'h02}, 1'b1);
        chk_val("R4", {flag_c, flag_z, 6'd0}, 8'h80);
        exec_chk(movlw(8'h02), 1'b1);
        exec_chk({6'b111100, 8'h02}, 1'b1);
        chk_val("R4", {flag_c, flag_z, 6'd0}, 8'hC0);
        exec_chk(movlw(8'h03), 1'b1);
        exec_chk({6'b111100, 8'h02}, 1'b1);
        chk_val("R4", w_out, 8'hFF);
        // R4 file minus W with low-nibble borrow: 0x10 - 0x01
        exec_chk(movlw(8'h10), 1'b1);
        exec_chk(byteop(4'b0000, 1'b1, 7'd20), 1'b1);
        exec_chk(movlw(8'h01), 1'b1);
        exec_chk(byteop(4'b0010, 1'b1, 7'd20), 1'b1);
        chk_val("R4", {flag_c, flag_dc, 6'd0}, 8'h80);
        // R7 rotate left 0xE6 with C=0
        exec_chk(movlw(8'h00), 1'b1);
        exec_chk({6'b111110, 8'h00}, 1'b1);
        exec_chk(movlw(8'hE6), 1'b1);
        exec_chk(byteop(4'b0000, 1'b1, 7'd30), 1'b1);
        exec_chk(byteop(4'b1101, 1'b0, 7'd30), 1'b1);
        chk_val("R7", w_out, 8'hCC);
        exec_chk(byteop(4'b1100, 1'b0, 7'd30), 1'b1);
        // R8 swap 0xA5
        exec_chk(movlw(8'hA5), 1'b1);
        exec_chk(byteop(4'b0000, 1'b1, 7'd31), 1'b1);
        exec_chk(byteop(4'b1110, 1'b0, 7'd31), 1'b1);
        chk_val("R8", w_out, 8'h5A);
        // R11 count-and-test reaching zero
        exec_chk(movlw(8'hFF), 1'b1);
        exec_chk(byteop(4'b0000, 1'b1, 7'd40), 1'b1);
        exec_chk(byteop(4'b1111, 1'b1, 7'd40), 1'b1);
        exec_chk(movlw(8'h01), 1'b1);
        exec_chk(byteop(4'b0000, 1'b1, 7'd41), 1'b1);
        exec_chk(byteop(4'b1011, 1'b0, 7'd41), 1'b1);
        // R6 clears, R9/R10 bit ops
        exec_chk(byteop(4'b0001, 1'b0, 7'd0), 1'b1);
        exec_chk(byteop(4'b0001, 1'b1, 7'd41), 1'b1);
        exec_chk({4'b0101, 3'd7, 7'd41}, 1'b1);
        exec_chk({4'b0111, 3'd7, 7'd41}, 1'b1);
        exec_chk({4'b0110, 3'd7, 7'd41}, 1'b1);
        exec_chk({4'b0100, 3'd7, 7'd41}, 1'b1);
        exec_chk({4'b0110, 3'd7, 7'd41}, 1'b1);
        // R13 and R14
        exec_chk({2'b10, 12'hABC}, 1'b1);
        exec_chk({6'b110100, 8'h33}, 1'b1);
        exec_chk(byteop(4'b0001, 1'b1, 7'd5), 1'b0);

        for (int n = 0; n < NRAND; n++) begin
            exec_chk(rand_instr(), ($urandom_range(0, 15) != 0));
        end
        // read back every entry (R2, R9)
        for (int i = 0; i < 128; i++) begin
            exec_chk(byteop(4'b1000, 1'b0, 7'(i)), 1'b1);
        end

        @(negedge clk);
        instr_valid = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule